// File: doc/BRIEF.md
# Answer-to-reset convention detector

This block sits between a smart-card character receiver and the firmware-facing byte path. Once a new card session is armed, it inspects the first character the card returns. That character is the one that opens the answer-to-reset, and it tells the block whether the card uses direct or inverse convention. The convention is held for the rest of the session. When the card is inverse, every later received byte, and every byte the host sends out, is rewritten so that software only ever handles direct-convention values.

The block checks parity on the initial character. On a parity error it can request a repeat from the card by raising a break request, which holds the I/O line low during the guard period. Three configuration inputs switch off, each on its own, the data conversion, the parity check on the initial character, and the break.

The timebase is a parameter giving clock cycles per elementary time unit (ETU). The break starts half an ETU after the character is delivered and lasts one and a half ETU.

Top module: `ts_conv_detect`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, every output is 0.
- R2: After `session_start`, raw byte 0x3B with good parity gives `rx_out_valid` with data 0x3B one cycle later. In the same cycle `conv_known`=1 and `conv_inverse`=0.
- R3: After `session_start`, raw byte 0x03 with good parity gives `rx_out_data`=0x3F one cycle later. In the same cycle `conv_known`=1 and `conv_inverse`=1.
- R4: Any other initial byte pulses `ts_err` for one cycle one cycle later. No byte is forwarded, and the block keeps waiting for an initial character.
- R5: In a session, received bytes appear one cycle later. They pass unchanged in direct convention. In inverse convention output bit i is the complement of input bit 7-i.
- R6: With `cfg_conv_off`=1, forwarded bytes equal the raw bytes. This includes 0x03 for an inverse initial character. The convention flags are still learned.
- R7: `tx_out_valid`/`tx_out_data` follow `tx_valid`/`tx_data` one cycle later. They use the same transform as R5 whenever an inverse session is known and `cfg_conv_off`=0.
- R8: Initial-character parity passes in direct convention when the 9 bits (data plus parity) hold an even count of ones. In inverse convention it passes when that count is odd. On failure `par_err` pulses one cycle later, no byte is forwarded, and waiting continues. `cfg_par_off`=1 accepts the character regardless.
- R9: On an initial-character parity error with `cfg_brk_off`=0, `io_brk` rises ETU/2 cycles after the receiving edge and stays high for 3*ETU/2 cycles. With `cfg_brk_off`=1 it stays low while `par_err` still pulses.
- R10: After the initial character, parity is not checked. A byte with wrong parity is forwarded and raises no `par_err`.
- R11: Bytes received before any `session_start` are ignored. A new `session_start` clears `conv_known` and `conv_inverse` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| session_start | input | 1 | Arms detection of a new initial character |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received data bits, bit 0 first on the line |
| rx_parity | input | 1 | Received parity bit as seen on the line |
| tx_valid | input | 1 | Outgoing byte strobe |
| tx_data | input | 8 | Outgoing byte in direct convention |
| cfg_conv_off | input | 1 | Disable convention conversion |
| cfg_par_off | input | 1 | Disable initial-character parity check |
| cfg_brk_off | input | 1 | Disable break on parity error |
| rx_out_valid | output | 1 | Forwarded byte strobe |
| rx_out_data | output | 8 | Forwarded byte |
| tx_out_valid | output | 1 | Line-side outgoing byte strobe |
| tx_out_data | output | 8 | Line-side outgoing byte |
| conv_known | output | 1 | Convention learned for this session |
| conv_inverse | output | 1 | Learned convention is inverse |
| ts_err | output | 1 | Invalid initial character strobe |
| par_err | output | 1 | Initial-character parity error strobe |
| io_brk | output | 1 | High while I/O must be held low |

## Verification
Byte results, convention flags and error strobes all come from one register stage. Each is due on the first falling edge after the rising edge that sampled the strobe, and the bench drives on falling edges and compares at exactly that falling edge. The break is checked over a window of falling edges that counts from the sampling edge. The bench records the first edge offset with `io_brk` high and the number of high samples, and compares them with ETU/2 and 3*ETU/2.

// File: rtl/ts_conv_pkg.sv
// Shared types and constants for the convention detector.
// Assumes 8-bit characters; line bit 0 is the first data bit received.
package ts_conv_pkg;

    localparam logic [7:0] TS_RAW_DIRECT  = 8'h3B;
    localparam logic [7:0] TS_RAW_INVERSE = 8'h03;

    typedef enum logic [1:0] {
        SS_IDLE    = 2'd0,
        SS_WAIT_TS = 2'd1,
        SS_SESSION = 2'd2
    } sess_state_t;

    typedef enum logic [1:0] {
        BP_IDLE  = 2'd0,
        BP_DELAY = 2'd1,
        BP_LOW   = 2'd2
    } brk_phase_t;

endpackage

// File: rtl/ts_decoder.sv
// Classifies a raw initial character and judges its parity for the
// convention it names. Purely combinational.
// Assumes raw bits are in line order.
module ts_decoder
    import ts_conv_pkg::*;
(
    input  logic [7:0] raw,
    input  logic       raw_par,
    output logic       is_direct,
    output logic       is_inverse,
    output logic       par_ok
);

    logic ones_odd;

    // Decode the initial character and evaluate parity.
    always_comb begin
        ones_odd   = ^{raw, raw_par};
        is_direct  = (raw == TS_RAW_DIRECT);
        is_inverse = (raw == TS_RAW_INVERSE);
        // Inverse convention: parity bit is complemented on the line.
        par_ok     = is_inverse ? ones_odd : !ones_odd;
    end

endmodule

// File: rtl/conv_xform.sv
// Inverse-convention byte transform: reverses bit order and complements.
// When en is low the byte passes unchanged. Combinational.
module conv_xform #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    input  logic         en,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Select the mirrored complemented bit or the straight bit.
        assign dout[i] = en ? ~din[W-1-i] : din[i];
    end

endmodule

// File: rtl/brk_gen.sv
// Break timer: after a trigger, waits DELAY_CYC cycles then holds brk
// high for LOW_CYC cycles. Retriggers are ignored while busy.
// Assumes DELAY_CYC >= 1 and LOW_CYC >= 1.
module brk_gen
    import ts_conv_pkg::*;
#(
    parameter int DELAY_CYC = 8,
    parameter int LOW_CYC   = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic brk
);

    localparam int MAXC = (DELAY_CYC > LOW_CYC) ? DELAY_CYC : LOW_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    brk_phase_t    phase;
    logic [CW-1:0] cnt;

    // Phase sequencing and down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= BP_IDLE;
            cnt   <= '0;
            brk   <= 1'b0;
        end else begin
            case (phase)
                BP_IDLE: if (trigger) begin
                    phase <= BP_DELAY;
                    cnt   <= CW'(DELAY_CYC - 1);
                end
                BP_DELAY: if (cnt == '0) begin
                    phase <= BP_LOW;
                    cnt   <= CW'(LOW_CYC - 1);
                    brk   <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                BP_LOW: if (cnt == '0) begin
                    phase <= BP_IDLE;
                    brk   <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: phase <= BP_IDLE;
            endcase
        end
    end

    // R9: break only begins from the delay phase
    a_r9_brk_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk) |-> $past(phase) == BP_DELAY);

    // R9: break output is low whenever the timer is idle
    a_r9_idle_no_brk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == BP_IDLE) |-> !brk);

endmodule

// File: rtl/ts_conv_detect.sv
// Answer-to-reset convention detector. Learns direct/inverse convention
// from the initial character after session_start, converts received and
// outgoing bytes, checks initial-character parity and times a break.
// Assumes one character per rx_valid strobe, already framed.
module ts_conv_detect
    import ts_conv_pkg::*;
#(
    parameter int ETU_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       session_start,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_parity,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    input  logic       cfg_conv_off,
    input  logic       cfg_par_off,
    input  logic       cfg_brk_off,
    output logic       rx_out_valid,
    output logic [7:0] rx_out_data,
    output logic       tx_out_valid,
    output logic [7:0] tx_out_data,
    output logic       conv_known,
    output logic       conv_inverse,
    output logic       ts_err,
    output logic       par_err,
    output logic       io_brk
);

    localparam int BRK_DELAY = ETU_CYC / 2;
    localparam int BRK_LEN   = ETU_CYC + ETU_CYC / 2;

    sess_state_t state;
    logic        d_direct, d_inverse, d_par_ok;
    logic        rx_xf_en, tx_xf_en;
    logic [7:0]  rx_xf, tx_xf;
    logic        ts_accept, ts_par_bad, brk_fire;

    ts_decoder u_dec (
        .raw        (rx_data),
        .raw_par    (rx_parity),
        .is_direct  (d_direct),
        .is_inverse (d_inverse),
        .par_ok     (d_par_ok)
    );

    // Pick the convention used to convert the current received byte.
    always_comb begin
        rx_xf_en   = ((state == SS_WAIT_TS) ? d_inverse : conv_inverse) && !cfg_conv_off;
        tx_xf_en   = conv_known && conv_inverse && !cfg_conv_off;
        ts_par_bad = !d_par_ok && !cfg_par_off;
        ts_accept  = (state == SS_WAIT_TS) && rx_valid && !session_start
                     && (d_direct || d_inverse);
        brk_fire   = ts_accept && ts_par_bad && !cfg_brk_off;
    end

    conv_xform #(.W(8)) u_rx_xf (.din(rx_data), .en(rx_xf_en), .dout(rx_xf));
    conv_xform #(.W(8)) u_tx_xf (.din(tx_data), .en(tx_xf_en), .dout(tx_xf));

    // Session state, convention flags, forwarded bytes and error strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= SS_IDLE;
            conv_known   <= 1'b0;
            conv_inverse <= 1'b0;
            rx_out_valid <= 1'b0;
            rx_out_data  <= '0;
            ts_err       <= 1'b0;
            par_err      <= 1'b0;
        end else begin
            rx_out_valid <= 1'b0;
            ts_err       <= 1'b0;
            par_err      <= 1'b0;
            if (session_start) begin
                state        <= SS_WAIT_TS;
                conv_known   <= 1'b0;
                conv_inverse <= 1'b0;
            end else if (rx_valid) begin
                case (state)
                    SS_WAIT_TS: begin
                        if (!(d_direct || d_inverse)) begin
                            ts_err <= 1'b1;
                        end else if (ts_par_bad) begin
                            par_err <= 1'b1;
                        end else begin
                            state        <= SS_SESSION;
                            conv_known   <= 1'b1;
                            conv_inverse <= d_inverse;
                            rx_out_valid <= 1'b1;
                            rx_out_data  <= rx_xf;
                        end
                    end
                    SS_SESSION: begin
                        rx_out_valid <= 1'b1;
                        rx_out_data  <= rx_xf;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outgoing byte path, one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_out_valid <= 1'b0;
            tx_out_data  <= '0;
        end else begin
            tx_out_valid <= tx_valid;
            if (tx_valid) tx_out_data <= tx_xf;
        end
    end

    brk_gen #(.DELAY_CYC(BRK_DELAY), .LOW_CYC(BRK_LEN)) u_brk (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (brk_fire),
        .brk     (io_brk)
    );

    // R2: a learned convention holds until a new session is armed
    a_r2_conv_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_known && !session_start) |=> (conv_known && $stable(conv_inverse)));

    // R4: error strobes and forwarded bytes are mutually exclusive
    a_r4_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ts_err, par_err, rx_out_valid}));

    // R4: an invalid initial character never coincides with a learned convention
    a_r4_ts_err_unlearned: assert property (@(posedge clk) disable iff (!rst_n)
        ts_err |-> !conv_known);

    // R6: with conversion off the forwarded byte is the raw byte
    a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_out_valid && $past(cfg_conv_off)) |-> rx_out_data == $past(rx_data));

    // R11: a new session clears the convention on the next cycle
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        session_start |=> !conv_known && !conv_inverse);

endmodule

// File: tb/ts_conv_detect_tb.sv
module ts_conv_detect_tb;

    localparam int ETU = 16;
    localparam int HALF = ETU / 2;
    localparam int BLEN = ETU + ETU / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       session_start = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_parity = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       cfg_conv_off = 1'b0;
    logic       cfg_par_off = 1'b0;
    logic       cfg_brk_off = 1'b0;
    logic       rx_out_valid, tx_out_valid, conv_known, conv_inverse;
    logic       ts_err, par_err, io_brk;
    logic [7:0] rx_out_data, tx_out_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    ts_conv_detect #(.ETU_CYC(ETU)) u_dut (
        .clk(clk), .rst_n(rst_n), .session_start(session_start),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity(rx_parity),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .cfg_conv_off(cfg_conv_off), .cfg_par_off(cfg_par_off),
        .cfg_brk_off(cfg_brk_off),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
        .conv_known(conv_known), .conv_inverse(conv_inverse),
        .ts_err(ts_err), .par_err(par_err), .io_brk(io_brk)
    );

    function automatic logic [7:0] inv_map(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = ~b[7-i];
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            finish_run();
        end
    end

    // Drive one received char; on return the registered results are visible.
    task automatic rx_char(input logic [7:0] d, input logic p);
        rx_valid = 1'b1; rx_data = d; rx_parity = p;
        @(posedge clk); @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic arm();
        session_start = 1'b1;
        @(posedge clk); @(negedge clk);
        session_start = 1'b0;
        check("R11 known cleared", conv_known, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", {rx_out_valid, tx_out_valid, conv_known,
              conv_inverse, ts_err, par_err, io_brk}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", {rx_out_valid, conv_known, io_brk}, 0);
    endtask

    task automatic t_idle_ignore();
        rx_char(8'h3B, 1'b1);
        check("R11 idle byte ignored", {rx_out_valid, conv_known, ts_err}, 0);
    endtask

    task automatic t_direct();
        arm();
        rx_char(8'h3B, 1'b1);
        check("R2 valid", rx_out_valid, 1);
        check("R2 data", rx_out_data, 8'h3B);
        check("R2 flags", {conv_known, conv_inverse}, 2'b10);
        rx_char(8'hA5, 1'b0);
        check("R5 direct pass", rx_out_data, 8'hA5);
        rx_char(8'h5A, 1'b1);   // wrong parity, unchecked after initial char
        check("R10 no par_err", par_err, 0);
        check("R10 forwarded", {rx_out_valid, rx_out_data}, {1'b1, 8'h5A});
    endtask

    task automatic t_inverse();
        arm();
        rx_char(8'h03, 1'b1);
        check("R3 data", rx_out_data, 8'h3F);
        check("R3 flags", {conv_known, conv_inverse}, 2'b11);
        rx_char(8'h12, 1'b0);
        check("R5 inverse data", rx_out_data, inv_map(8'h12));
        rx_char(8'hF0, 1'b0);
        check("R5 inverse data 2", rx_out_data, inv_map(8'hF0));
        tx_valid = 1'b1; tx_data = 8'h81;
        @(posedge clk); @(negedge clk);
        tx_valid = 1'b0;
        check("R7 tx inverse", {tx_out_valid, tx_out_data}, {1'b1, inv_map(8'h81)});
        cfg_conv_off = 1'b1;
        tx_valid = 1'b1; tx_data = 8'h81;
        @(posedge clk); @(negedge clk);
        tx_valid = 1'b0;
        check("R7 tx conv off", tx_out_data, 8'h81);
        rx_char(8'h12, 1'b0);
        check("R6 session raw", rx_out_data, 8'h12);
        cfg_conv_off = 1'b0;
    endtask

    task automatic t_tx_direct();
        arm();
        rx_char(8'h3B, 1'b1);
        tx_valid = 1'b1; tx_data = 8'h6C;
        @(posedge clk); @(negedge clk);
        tx_valid = 1'b0;
        check("R7 tx direct", {tx_out_valid, tx_out_data}, {1'b1, 8'h6C});
        @(negedge clk);
        check("R7 tx valid drops", tx_out_valid, 0);
    endtask

    task automatic t_conv_off_ts();
        arm();
        cfg_conv_off = 1'b1;
        rx_char(8'h03, 1'b1);
        check("R6 ts raw", rx_out_data, 8'h03);
        check("R6 flags learned", {conv_known, conv_inverse}, 2'b11);
        cfg_conv_off = 1'b0;
    endtask

    task automatic t_bad_ts();
        arm();
        rx_char(8'h3F, 1'b0);
        check("R4 ts_err", ts_err, 1);
        check("R4 no byte", {rx_out_valid, conv_known}, 0);
        @(negedge clk);
        check("R4 one cycle", ts_err, 0);
        rx_char(8'h3B, 1'b1);
        check("R4 still waiting", {rx_out_valid, conv_known}, 2'b11);
    endtask

    // Parity error on initial char; measure the break window.
    task automatic t_break(input logic [7:0] ts, input logic bad_p, input logic brk_off);
        int first = -1;
        int highs = 0;
        arm();
        cfg_brk_off = brk_off;
        rx_char(ts, bad_p);
        check("R8 par_err", par_err, 1);
        check("R8 no byte", {rx_out_valid, conv_known}, 0);
        for (int k = 0; k < HALF + BLEN + 6; k++) begin
            if (k > 0) @(negedge clk);
            if (io_brk) begin
                if (first < 0) first = k;
                highs++;
            end
        end
        if (brk_off) begin
            check("R9 break disabled", highs, 0);
        end else begin
            check("R9 break start", first, HALF);
            check("R9 break length", highs, BLEN);
        end
        cfg_brk_off = 1'b0;
        rx_char(ts, ~bad_p);
        check("R8 retry accepted", {rx_out_valid, conv_known}, 2'b11);
    endtask

    task automatic t_par_off();
        arm();
        cfg_par_off = 1'b1;
        rx_char(8'h03, 1'b0);
        check("R8 par off accepts", {par_err, rx_out_valid, rx_out_data}, {2'b01, 8'h3F});
        check("R9 no break", io_brk, 0);
        cfg_par_off = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_ignore();
        t_direct();
        t_inverse();
        t_tx_direct();
        t_conv_off_ts();
        t_bad_ts();
        t_break(8'h3B, 1'b0, 1'b0);
        t_break(8'h03, 1'b0, 1'b0);
        t_break(8'h3B, 1'b0, 1'b1);
        t_par_off();
        finish_run();
    end

endmodule